// File: doc/BRIEF.md
# Receive Character Queue with Line Status

This block sits between a UART's receive shift register and the CPU. Each finished character arrives with its parity-error, framing-error and break flags, and the flags are stored beside the data byte in a 128-entry first-in first-out queue. The CPU reads characters from the head of the queue. A line status byte tells the CPU whether data is waiting, whether an overrun has happened, which error flags belong to the head character, and whether any character still in the queue carries an error.

A line held low for many character times produces only one queued break character. Break capture re-arms after the serial line has been seen idle (high) again. When a character finishes while the queue is full, that character is dropped, the characters already stored are kept unchanged, and a sticky overrun bit is raised. The two transmit-side bits of the status byte are formed from status inputs supplied by the transmit path.

Top module: `rx_status_fifo`

## Requirements
- R1: Characters leave in the order they were accepted. `rd_data` always shows the head character, shows 0 when the queue is empty, and a `rd_data_en` pulse removes the head. Up to DEPTH=128 characters are held.
- R2: `lsr` bit 0 is 1 exactly while the queue holds at least one character.
- R3: A character offered with `rx_valid` while the queue is full, with no removal in the same cycle, is discarded, and the stored characters are unchanged. `lsr` bit 1 (overrun) becomes 1 in the next cycle.
- R4: Overrun stays set until a cycle with `lsr_rd` high and no new overrun in that cycle. If both happen in the same cycle, the bit stays set.
- R5: `lsr` bit 2 is the parity flag, bit 3 the framing flag and bit 4 the break flag of the head character. All three are 0 when the queue is empty.
- R6: `lsr` bit 7 is 1 while at least one stored character has any of its three flags set. It returns to 0 once the last such character is removed.
- R7: A character offered with `rx_brk` set is queued only if break capture is armed. Queuing it disarms capture. Capture re-arms in any later cycle where `rx_line` is 1. Break characters offered while capture is disarmed are dropped and do not cause an overrun.
- R8: A character offered in the same cycle that the head is removed from a full queue is accepted, and no overrun is raised.
- R9: `lsr` bit 5 equals `tx_fifo_empty`. `lsr` bit 6 equals `tx_fifo_empty & tx_shift_empty`.
- R10: `rd_data_en` on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive shift register offers a finished character |
| rx_data | input | 8 | Character data byte |
| rx_par_err | input | 1 | Parity error flag of the character |
| rx_frm_err | input | 1 | Framing error flag of the character |
| rx_brk | input | 1 | Character is a break indication |
| rx_line | input | 1 | Current serial receive line level (1 = idle) |
| rd_data_en | input | 1 | CPU removes the head character |
| rd_data | output | 8 | Head character data |
| lsr_rd | input | 1 | CPU reads the line status byte (clears overrun) |
| lsr | output | 8 | Line status byte |
| tx_fifo_empty | input | 1 | Transmit queue is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |

## Verification
The hardest situation to reach is a completely full queue. Overrun, its clearing race with a status read, and the accept-while-removing case can all occur only there. The bench fills all 128 entries with a counting pattern. It then drives each of these situations at the boundary, and afterwards drains the whole queue to confirm that no stored byte was disturbed and that the swapped-in byte arrived last. Break collapsing needs `rx_line` held low across several offered break characters and then a single idle cycle, so the bench controls the line level separately from the character handshake.

// File: rtl/rx_status_fifo_pkg.sv
package rx_status_fifo_pkg;

    typedef struct packed {
        logic [7:0] data;
        logic       par_err;
        logic       frm_err;
        logic       brk;
    } rx_char_t;

    localparam int CHAR_W = $bits(rx_char_t);

    function automatic logic char_flagged(input rx_char_t c);
        return c.par_err | c.frm_err | c.brk;
    endfunction

    typedef enum logic [2:0] {
        LSR_READY = 3'd0,
        LSR_OVR   = 3'd1,
        LSR_PAR   = 3'd2,
        LSR_FRM   = 3'd3,
        LSR_BRK   = 3'd4,
        LSR_THRE  = 3'd5,
        LSR_TEMT  = 3'd6,
        LSR_ERRS  = 3'd7
    } lsr_bit_e;

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rx_status_fifo_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  rx_char_t         push_char,
    input  logic             pop_req,
    output logic             push_ok,
    output logic             pop_ok,
    output rx_char_t         head,
    output logic [CW-1:0]    count,
    output logic             full
);
    rx_char_t        mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign pop_ok  = pop_req && (count != '0);
    assign push_ok = push_req && (!full || pop_ok);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_char;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_full_swap_r8: assert property (@(posedge clk) disable iff (rst)
        (full && push_req && pop_req) |=> full);
endmodule

// File: rtl/rxq_errcnt.sv
module rxq_errcnt #(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic any_err
);
    logic [CW-1:0] n_err;

    always_ff @(posedge clk) begin
        if (rst) n_err <= '0;
        else     n_err <= n_err + CW'(inc) - CW'(dec);
    end

    assign any_err = (n_err != '0);

    p_err_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc) |-> (n_err != '0));
endmodule

// File: rtl/rxq_brkgate.sv
module rxq_brkgate (
    input  logic clk,
    input  logic rst,
    input  logic valid_in,
    input  logic is_brk,
    input  logic line_idle,
    output logic valid_out
);
    logic armed;

    assign valid_out = valid_in && (!is_brk || armed);

    always_ff @(posedge clk) begin
        if (rst)                               armed <= 1'b1;
        else if (valid_in && is_brk && armed)  armed <= 1'b0;
        else if (line_idle)                    armed <= 1'b1;
    end

    p_brk_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (valid_in && is_brk && !line_idle) |=> !(valid_in && is_brk && valid_out));
endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
    import rx_status_fifo_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_par_err,
    input  logic       rx_frm_err,
    input  logic       rx_brk,
    input  logic       rx_line,
    input  logic       rd_data_en,
    output logic [7:0] rd_data,
    input  logic       lsr_rd,
    output logic [7:0] lsr,
    input  logic       tx_fifo_empty,
    input  logic       tx_shift_empty
);
    rx_char_t      in_char, head;
    logic          gated_valid, push_ok, pop_ok, full, any_err, ovr, ovr_set, nonempty;
    logic [CW-1:0] count;

    assign in_char = '{data: rx_data, par_err: rx_par_err, frm_err: rx_frm_err, brk: rx_brk};

    rxq_brkgate u_brk (
        .clk(clk), .rst(rst), .valid_in(rx_valid), .is_brk(rx_brk),
        .line_idle(rx_line), .valid_out(gated_valid)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .push_req(gated_valid), .push_char(in_char),
        .pop_req(rd_data_en), .push_ok(push_ok), .pop_ok(pop_ok),
        .head(head), .count(count), .full(full)
    );

    rxq_errcnt #(.DEPTH(DEPTH)) u_err (
        .clk(clk), .rst(rst),
        .inc(push_ok && char_flagged(in_char)),
        .dec(pop_ok && char_flagged(head)),
        .any_err(any_err)
    );

    assign ovr_set  = gated_valid && !push_ok;
    assign nonempty = (count != '0);

    always_ff @(posedge clk) begin
        if (rst)          ovr <= 1'b0;
        else if (ovr_set) ovr <= 1'b1;
        else if (lsr_rd)  ovr <= 1'b0;
    end

    assign rd_data = nonempty ? head.data : 8'h00;

    always_comb begin
        lsr            = '0;
        lsr[LSR_READY] = nonempty;
        lsr[LSR_OVR]   = ovr;
        lsr[LSR_PAR]   = nonempty && head.par_err;
        lsr[LSR_FRM]   = nonempty && head.frm_err;
        lsr[LSR_BRK]   = nonempty && head.brk;
        lsr[LSR_THRE]  = tx_fifo_empty;
        lsr[LSR_TEMT]  = tx_fifo_empty && tx_shift_empty;
        lsr[LSR_ERRS]  = any_err;
    end

    p_overrun_set_r3: assert property (@(posedge clk) disable iff (rst)
        (gated_valid && full && !rd_data_en) |=> lsr[LSR_OVR]);

    p_overrun_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && !(gated_valid && full && !rd_data_en)) |=> !lsr[LSR_OVR]);

    p_empty_clean_r6: assert property (@(posedge clk) disable iff (rst)
        !lsr[LSR_READY] |-> !lsr[LSR_ERRS]);

    p_ready_after_push_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_brk) |=> lsr[LSR_READY]);
endmodule

// File: tb/rx_status_fifo_test.sv
module rx_status_fifo_test;
    logic clk = 0, rst = 1;
    logic rx_valid = 0, rx_par_err = 0, rx_frm_err = 0, rx_brk = 0, rx_line = 1;
    logic [7:0] rx_data = 0;
    logic rd_data_en = 0, lsr_rd = 0, tx_fifo_empty = 1, tx_shift_empty = 1;
    logic [7:0] rd_data, lsr;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    rx_status_fifo uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
        .rx_line(rx_line), .rd_data_en(rd_data_en), .rd_data(rd_data),
        .lsr_rd(lsr_rd), .lsr(lsr), .tx_fifo_empty(tx_fifo_empty),
        .tx_shift_empty(tx_shift_empty)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycle(input logic v, input logic [7:0] d, input logic p, input logic f,
                         input logic b, input logic pop, input logic lr);
        rx_valid = v; rx_data = d; rx_par_err = p; rx_frm_err = f; rx_brk = b;
        rd_data_en = pop; lsr_rd = lr;
        @(negedge clk);
        rx_valid = 0; rx_par_err = 0; rx_frm_err = 0; rx_brk = 0; rd_data_en = 0; lsr_rd = 0;
    endtask

    task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b);
        cycle(1, d, p, f, b, 0, 0);
    endtask

    task automatic pop();
        cycle(0, 0, 0, 0, 0, 1, 0);
    endtask

    task automatic t_reset();
        chk("R2 reset lsr", lsr, 8'h60);
        chk("R1 reset rd_data", rd_data, 8'h00);
    endtask

    task automatic t_order();
        push(8'h11, 0, 0, 0); push(8'h22, 0, 0, 0); push(8'h33, 0, 0, 0);
        chk("R2 ready", {7'b0, lsr[0]}, 8'h01);
        chk("R1 head0", rd_data, 8'h11); pop();
        chk("R1 head1", rd_data, 8'h22); pop();
        chk("R1 head2", rd_data, 8'h33); pop();
        chk("R2 empty", {7'b0, lsr[0]}, 8'h00);
    endtask

    task automatic t_flags();
        push(8'hA0, 0, 0, 0); push(8'hA1, 1, 0, 0); push(8'hA2, 0, 1, 0);
        push(8'h00, 0, 0, 1); push(8'hA4, 0, 0, 0);
        chk("R5 clean head", lsr & 8'h9C, 8'h80);
        pop(); chk("R5 parity head", lsr & 8'h9C, 8'h84);
        pop(); chk("R5 framing head", lsr & 8'h9C, 8'h88);
        pop(); chk("R5 break head", lsr & 8'h9C, 8'h90);
        chk("R6 summary set", {7'b0, lsr[7]}, 8'h01);
        pop(); chk("R6 summary cleared", lsr & 8'h9C, 8'h00);
        chk("R1 last data", rd_data, 8'hA4);
        pop(); chk("R5 empty flags", lsr & 8'h9D, 8'h00);
    endtask

    task automatic t_overrun();
        for (int i = 0; i < 128; i++) push(8'(i), 0, 0, 0);
        chk("R3 no ovr when just full", {7'b0, lsr[1]}, 8'h00);
        push(8'hEE, 1, 0, 0);
        chk("R3 ovr set", {7'b0, lsr[1]}, 8'h01);
        chk("R3 head intact", rd_data, 8'h00);
        chk("R3 dropped char flags not counted", {7'b0, lsr[7]}, 8'h00);
        cycle(0, 0, 0, 0, 0, 0, 1);
        chk("R4 ovr cleared by read", {7'b0, lsr[1]}, 8'h00);
        cycle(1, 8'hEE, 0, 0, 0, 0, 1);
        chk("R4 set wins over read", {7'b0, lsr[1]}, 8'h01);
        cycle(0, 0, 0, 0, 0, 0, 1);
        cycle(1, 8'hC5, 0, 0, 0, 1, 0);
        chk("R8 no ovr on swap", {7'b0, lsr[1]}, 8'h00);
        for (int i = 1; i < 128; i++) begin
            chk("R3 drain order", rd_data, 8'(i));
            pop();
        end
        chk("R8 swapped char last", rd_data, 8'hC5);
        pop();
        chk("R2 drained", {7'b0, lsr[0]}, 8'h00);
    endtask

    task automatic t_break();
        rx_line = 0;
        push(8'h00, 0, 1, 1); push(8'h00, 0, 1, 1); push(8'h00, 0, 1, 1);
        pop();
        chk("R7 one break queued", {7'b0, lsr[0]}, 8'h00);
        chk("R7 no ovr from drop", {7'b0, lsr[1]}, 8'h00);
        rx_line = 1; @(negedge clk); rx_line = 0;
        push(8'h00, 0, 0, 1);
        chk("R7 rearmed break queued", lsr & 8'h91, 8'h91);
        pop(); rx_line = 1; @(negedge clk);
    endtask

    task automatic t_tx();
        tx_fifo_empty = 0; tx_shift_empty = 1; #1;
        chk("R9 tx busy", lsr & 8'h60, 8'h00);
        tx_fifo_empty = 1; tx_shift_empty = 0; #1;
        chk("R9 shift busy", lsr & 8'h60, 8'h20);
        tx_fifo_empty = 1; tx_shift_empty = 1; #1;
        chk("R9 both empty", lsr & 8'h60, 8'h60);
    endtask

    task automatic t_pop_empty();
        pop(); pop();
        push(8'h5A, 0, 0, 0);
        chk("R10 data after empty pop", rd_data, 8'h5A);
        pop();
        chk("R10 empty again", {7'b0, lsr[0]}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset(); t_order(); t_flags(); t_overrun(); t_break(); t_tx(); t_pop_empty();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule